// File: doc/BRIEF.md
# Instruction Stage Sequencer

This block drives the sub-stages of one instruction at a time. A stage counter moves forward by one on every clock while the block runs. A decoder turns the count into a one-hot vector, so each clock enables the next group of operations. The last stage is not fixed in the logic. It comes from an input and is found by a bitwise equality test against the count.

When the count equals that terminal value, the block asserts a completion pulse for that cycle. On the next edge it returns the stage count to 0 and steps a separate instruction index, so the following instruction starts at stage 0. Dropping the run input freezes both counts and removes every stage enable. Instruction decode sits outside the block and is driven by the stage vector.

Top module: `instr_stage_seq`

## Requirements
- R1: While rst_ni is low, the stage count and the instruction index are 0. After release with run_i high, stage_en_o equals 16'h0001 and instr_idx_o equals 0.
- R2: While run_i is high and the stage count is k, stage_en_o has bit k set and no other bit set. While run_i is low, stage_en_o is all zero.
- R3: On each rising edge with run_i high and the count not equal to last_stage_i, the stage count rises by one. A count of 15 wraps to 0 without a completion pulse.
- R4: done_o is high in exactly those cycles where run_i is high and the stage count equals last_stage_i. The next edge sets the stage count to 0.
- R5: Each edge that follows a cycle with done_o high adds one to instr_idx_o, modulo 2^INSTR_W (256 by default). No other edge changes instr_idx_o.
- R6: While run_i is low, done_o is low and an edge changes neither the stage count nor instr_idx_o.
- R7: With last_stage_i equal to 0, done_o stays high, stage_en_o stays 16'h0001 and instr_idx_o rises on every edge.
- R8: last_stage_i is compared live in every cycle. A value written mid-instruction takes effect at once. A value below the current count lets the count run to 15, wrap to 0 and then climb back up to the new terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable. Low freezes the sequencer. |
| last_stage_i | input | STAGE_W (4) | Terminal stage number |
| stage_en_o | output | 2^STAGE_W (16) | One-hot stage enables |
| done_o | output | 1 | Completion pulse during the final stage |
| instr_idx_o | output | INSTR_W (8) | Current instruction index |

## Verification
stage_en_o and done_o are combinational from the registered stage count and the live inputs. They are due in the same cycle as a change on run_i or last_stage_i. The stage count and instr_idx_o move one edge after the cycle that enables them. The bench changes inputs just after a falling edge. It updates its own model of both counts at each rising edge and compares all three outputs a nanosecond after the next falling edge, once every register and combinational path has settled. Each scenario runs long enough to cover a wrap and at least one completion.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned DEF_STAGE_W = 4;
  localparam int unsigned DEF_INSTR_W = 8;
endpackage

// File: rtl/seq_cnt.sv
module seq_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/seq_eq.sv
module seq_eq #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign eq_o = &bit_eq;
endmodule

// File: rtl/seq_dec.sv
module seq_dec #(
  parameter int unsigned W = 4,
  localparam int unsigned N = 1 << W
) (
  input  logic         en_i,
  input  logic [W-1:0] sel_i,
  output logic [N-1:0] hot_o
);
  for (genvar k = 0; k < N; k++) begin : g_line
    assign hot_o[k] = en_i && (sel_i == W'(k));
  end
endmodule

// File: rtl/instr_stage_seq.sv
module instr_stage_seq
  import seq_pkg::*;
#(
  parameter int unsigned STAGE_W = DEF_STAGE_W,
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  localparam int unsigned N_STAGE = 1 << STAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [STAGE_W-1:0] last_stage_i,
  output logic [N_STAGE-1:0] stage_en_o,
  output logic               done_o,
  output logic [INSTR_W-1:0] instr_idx_o
);
  logic [STAGE_W-1:0] stage_cnt;
  logic               at_last;
  logic               wrap;

  seq_eq #(.W(STAGE_W)) i_eq (
    .a_i  (stage_cnt),
    .b_i  (last_stage_i),
    .eq_o (at_last)
  );

  assign wrap = run_i && at_last;

  seq_cnt #(.W(STAGE_W)) i_stage_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wrap),
    .inc_i  (run_i),
    .cnt_o  (stage_cnt)
  );

  seq_cnt #(.W(INSTR_W)) i_instr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .inc_i  (wrap),
    .cnt_o  (instr_idx_o)
  );

  seq_dec #(.W(STAGE_W)) i_dec (
    .en_i  (run_i),
    .sel_i (stage_cnt),
    .hot_o (stage_en_o)
  );

  assign done_o = wrap;

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> $onehot(stage_en_o));
  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (stage_en_o == '0));
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o) |=> stage_cnt == $past(stage_cnt) + STAGE_W'(1));
  a_r4_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> stage_cnt == '0);
  a_r5_instr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> instr_idx_o == $past(instr_idx_o) + INSTR_W'(1));
  a_r5_instr_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(instr_idx_o));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(stage_cnt) && $stable(instr_idx_o));
  a_r6_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !done_o);
endmodule

// File: tb/test_instr_stage_seq.sv
module test_instr_stage_seq;
  localparam int SW = 4;
  localparam int IW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          run_i = 1'b0;
  logic [SW-1:0] last_stage_i = '0;
  logic [15:0]   stage_en_o;
  logic          done_o;
  logic [IW-1:0] instr_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [SW-1:0] e_st = '0;
  logic [IW-1:0] e_ins = '0;
  logic          in_reset = 1'b1;

  always #4 clk_i = ~clk_i;

  instr_stage_seq i_instr_stage_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .last_stage_i(last_stage_i),
    .stage_en_o(stage_en_o), .done_o(done_o), .instr_idx_o(instr_idx_o)
  );

  // reference model, updated at each rising edge from requirement behaviour
  always @(posedge clk_i) begin
    if (!in_reset && run_i) begin
      if (e_st == last_stage_i) begin
        e_st  <= '0;
        e_ins <= e_ins + 1'b1;
      end else begin
        e_st <= e_st + 1'b1;
      end
    end
  end

  task automatic chk(input string tag);
    logic [15:0] x_en;
    logic        x_done;
    x_en   = run_i ? (16'(1) << e_st) : 16'h0;
    x_done = run_i && (e_st == last_stage_i);
    n_cmp += 3;
    if (stage_en_o !== x_en) begin
      n_bad++;
      $display("FAIL %s stage_en_o act=%h exp=%h", tag, stage_en_o, x_en);
    end
    if (done_o !== x_done) begin
      n_bad++;
      $display("FAIL %s done_o act=%b exp=%b", tag, done_o, x_done);
    end
    if (instr_idx_o !== e_ins) begin
      n_bad++;
      $display("FAIL %s instr_idx_o act=%0d exp=%0d", tag, instr_idx_o, e_ins);
    end
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
      chk(tag);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0; in_reset = 1'b1; run_i = 1'b0;
    e_st = '0; e_ins = '0;
    @(negedge clk_i); #1;
    chk("R1 in reset");
    rst_ni = 1'b1; in_reset = 1'b0; run_i = 1'b1; last_stage_i = 4'd5;
    #1;
    chk("R1 after release");
    if (stage_en_o !== 16'h0001) begin
      n_bad++;
      $display("FAIL R1 stage0 act=%h exp=0001", stage_en_o);
    end
    n_cmp++;
  endtask

  task automatic t_basic;
    last_stage_i = 4'd3;
    run_cycles(14, "R2 R3 R4 R5 basic");
  endtask

  task automatic t_hold;
    run_i = 1'b0;
    #1 chk("R6 run low");
    run_cycles(5, "R6 hold");
    run_i = 1'b1;
    #1 chk("R6 resume");
    run_cycles(3, "R6 after resume");
  endtask

  task automatic t_zero;
    last_stage_i = 4'd0;
    #1 chk("R7 zero");
    run_cycles(6, "R7 every cycle");
  endtask

  task automatic t_full;
    last_stage_i = 4'd15;
    run_cycles(34, "R3 R4 full length");
  endtask

  task automatic t_change;
    last_stage_i = 4'd12;
    run_cycles(9, "R8 climb");
    last_stage_i = 4'd4;
    #1 chk("R8 lowered");
    run_cycles(24, "R8 R3 wrap past");
    last_stage_i = 4'd7;
    run_cycles(10, "R8 raised");
  endtask

  task automatic t_instr_wrap;
    last_stage_i = 4'd0;
    run_cycles(260, "R5 index wrap");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_zero();
    t_full();
    t_change();
    t_instr_wrap();
    t_reset();
    run_cycles(4, "R1 second reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule